// File: doc/BRIEF.md
# Port Edge Interrupt Controller

This block manages one 8-bit general purpose input port in which only pin positions 7, 6, 1 and 0 exist. Each of those pins has four controls: a pull-device enable, a polarity bit, an interrupt enable and a sticky interrupt flag. The pin inputs are resynchronised into the block clock domain. The block then looks for the edge that each pin's polarity bit selects, and it latches every detected edge into that pin's flag. A single interrupt request is raised whenever a flagged pin also has its interrupt enabled.

The polarity bit does two jobs. It picks the active edge, falling for 0 and rising for 1. It also picks the direction of the pull device, which drives the pad's pull-up or pull-down enable whenever the pin's pull enable is set. Software reaches all controls through a small single-cycle register bus with a combinational read path.

Top module: `pedge_ctrl`

## Requirements
- R1: Only bit positions 7, 6, 1 and 0 (mask 0xC3) are implemented in each per-pin register. The other positions read as 0 and discard written data. Addresses 5 to 7 read as 0.
- R2: After reset, the pull-enable (address 1), polarity (address 2), interrupt-enable (address 3) and flag (address 4) registers read 0. Both pull outputs and irq are 0.
- R3: With polarity bit 0, a falling edge on an implemented pin sets its flag. The flag becomes readable after the third rising clock edge that follows the pin change, and not after the second.
- R4: With polarity bit 1, a rising edge on an implemented pin sets its flag. The opposite edge sets nothing.
- R5: pull_up_en[i] equals pull_enable[i] AND NOT polarity[i], and pull_dn_en[i] equals pull_enable[i] AND polarity[i]. The two outputs are never both high on the same pin.
- R6: irq is the OR over pins of (flag AND interrupt enable).
- R7: Writing 1 to a bit of the flag register (address 4) clears that flag. Writing 0 leaves it unchanged, and a flag never clears without such a write.
- R8: When an active edge is detected in the same cycle as a write-1 clear of that flag, the flag stays set.
- R9: Changing a polarity bit while the pin level is steady does not set the flag.
- R10: Level changes on reserved pin positions never set a flag.
- R11: Address 0 is read-only and returns the synchronised pin level masked by 0xC3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not selected |
| pin_in | input | 8 | Asynchronous port pin levels |
| pull_up_en | output | 8 | Pull-up device enable per pin |
| pull_dn_en | output | 8 | Pull-down device enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is R8, where an edge and a write-1 clear of the same flag must hit the same clock edge. The bench changes the pin on a falling clock edge and counts two rising edges through the synchroniser. It then places the clear write so that it is sampled on the third rising edge, which is exactly the edge where the detector fires. A second hard case is R9 together with R10: these show that flags follow the raw synchronised level, so that polarity rewrites and toggling reserved pins leave every flag clear.

// File: rtl/pedge_pkg.sv
package pedge_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_LEVEL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PULL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_POL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_IRQEN = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd4;
endpackage

// File: rtl/pedge_sync.sv
module pedge_sync #(
  parameter int          PORT_W    = 8,
  parameter logic [PORT_W-1:0] IMPL_MASK = 8'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] smp_cur,
  output logic [PORT_W-1:0] smp_prev
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic meta_q, cur_q, prev_q;
      logic meta_d, cur_d, prev_d;

      always_comb begin
        meta_d = pin_in[i];
        cur_d  = meta_q;
        prev_d = cur_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          cur_q  <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          meta_q <= meta_d;
          cur_q  <= cur_d;
          prev_q <= prev_d;
        end
      end

      assign smp_cur[i]  = cur_q;
      assign smp_prev[i] = prev_q;
    end else begin : g_rsvd
      assign smp_cur[i]  = 1'b0;
      assign smp_prev[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pedge_edge.sv
module pedge_edge #(
  parameter int          PORT_W    = 8,
  parameter logic [PORT_W-1:0] IMPL_MASK = 8'hC3
) (
  input  logic [PORT_W-1:0] smp_cur,
  input  logic [PORT_W-1:0] smp_prev,
  input  logic [PORT_W-1:0] pol_q,
  output logic [PORT_W-1:0] edge_hit
);
  logic [PORT_W-1:0] moved;

  always_comb begin
    moved    = smp_cur ^ smp_prev;
    // polarity 1: new level 1 means rising; polarity 0: new level 0 means falling
    edge_hit = moved & ~(smp_cur ^ pol_q) & IMPL_MASK;
  end
endmodule

// File: rtl/pedge_flags.sv
module pedge_flags #(
  parameter int          PORT_W    = 8,
  parameter logic [PORT_W-1:0] IMPL_MASK = 8'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] edge_hit,
  input  logic [PORT_W-1:0] clr_vec,
  output logic [PORT_W-1:0] flag_q
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic f_q, f_d, f_en;

      always_comb begin
        f_en = edge_hit[i] | clr_vec[i];
        // an edge in the clear cycle keeps the flag set
        f_d  = edge_hit[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    f_q <= 1'b0;
        else if (f_en) f_q <= f_d;
      end

      assign flag_q[i] = f_q;
    end else begin : g_rsvd
      assign flag_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pedge_regs.sv
module pedge_regs
  import pedge_pkg::*;
#(
  parameter int          PORT_W    = 8,
  parameter logic [PORT_W-1:0] IMPL_MASK = 8'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic [PORT_W-1:0] level,
  input  logic [PORT_W-1:0] flag_q,
  output logic [PORT_W-1:0] bus_rdata,
  output logic [PORT_W-1:0] pe_q,
  output logic [PORT_W-1:0] pol_q,
  output logic [PORT_W-1:0] ie_q,
  output logic [PORT_W-1:0] clr_vec
);
  logic              wr_any;
  logic              pe_en, pol_en, ie_en;
  logic [PORT_W-1:0] wmask;

  always_comb begin
    wr_any  = bus_sel & bus_wr;
    wmask   = bus_wdata & IMPL_MASK;
    pe_en   = wr_any && (bus_addr == A_PULL);
    pol_en  = wr_any && (bus_addr == A_POL);
    ie_en   = wr_any && (bus_addr == A_IRQEN);
    clr_vec = (wr_any && (bus_addr == A_FLAG)) ? wmask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_q <= '0;
    end else if (pe_en) begin
      pe_q <= wmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
    end else if (pol_en) begin
      pol_q <= wmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
    end else if (ie_en) begin
      ie_q <= wmask;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_LEVEL: bus_rdata = level & IMPL_MASK;
        A_PULL:  bus_rdata = pe_q;
        A_POL:   bus_rdata = pol_q;
        A_IRQEN: bus_rdata = ie_q;
        A_FLAG:  bus_rdata = flag_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pedge_ctrl.sv
module pedge_ctrl
  import pedge_pkg::*;
#(
  parameter int          PORT_W    = 8,
  parameter logic [PORT_W-1:0] IMPL_MASK = 8'hC3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pull_up_en,
  output logic [PORT_W-1:0] pull_dn_en,
  output logic              irq
);
  logic              rst_meta_q, rst_int_n;
  logic [PORT_W-1:0] smp_cur, smp_prev, edge_hit;
  logic [PORT_W-1:0] flag_q, pe_q, pol_q, ie_q, clr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  pedge_sync #(.PORT_W(PORT_W), .IMPL_MASK(IMPL_MASK)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pin_in   (pin_in),
    .smp_cur  (smp_cur),
    .smp_prev (smp_prev)
  );

  pedge_edge #(.PORT_W(PORT_W), .IMPL_MASK(IMPL_MASK)) u_edge (
    .smp_cur  (smp_cur),
    .smp_prev (smp_prev),
    .pol_q    (pol_q),
    .edge_hit (edge_hit)
  );

  pedge_flags #(.PORT_W(PORT_W), .IMPL_MASK(IMPL_MASK)) u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .edge_hit (edge_hit),
    .clr_vec  (clr_vec),
    .flag_q   (flag_q)
  );

  pedge_regs #(.PORT_W(PORT_W), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .level     (smp_cur),
    .flag_q    (flag_q),
    .bus_rdata (bus_rdata),
    .pe_q      (pe_q),
    .pol_q     (pol_q),
    .ie_q      (ie_q),
    .clr_vec   (clr_vec)
  );

  always_comb begin
    pull_up_en = pe_q & ~pol_q;
    pull_dn_en = pe_q & pol_q;
    irq        = |(flag_q & ie_q);
  end
endmodule

// File: rtl/pedge_ctrl_chk.sv
module pedge_ctrl_chk
  import pedge_pkg::*;
#(
  parameter int          PORT_W    = 8,
  parameter logic [PORT_W-1:0] IMPL_MASK = 8'hC3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq,
  input logic [PORT_W-1:0] pull_up_en,
  input logic [PORT_W-1:0] pull_dn_en,
  input logic [PORT_W-1:0] flag_q,
  input logic [PORT_W-1:0] ie_q,
  input logic [PORT_W-1:0] pol_q,
  input logic [PORT_W-1:0] smp_cur,
  input logic [PORT_W-1:0] smp_prev
);
  logic no_clear;
  assign no_clear = !(bus_sel && bus_wr && (bus_addr == A_FLAG));

  assert_pull_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up_en & pull_dn_en) == '0);

  assert_rsvd_pull_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_up_en | pull_dn_en) & ~IMPL_MASK) == '0);

  assert_irq_combine_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(flag_q & ie_q)));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    no_clear |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  for (genvar i = 0; i < PORT_W; i++) begin : g_edge
    if (IMPL_MASK[i]) begin : g_impl
      // covers R3 (polarity 0) and R4 (polarity 1); also R8 since clears lose
      assert_edge_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((smp_cur[i] != smp_prev[i]) && (smp_cur[i] == pol_q[i])) |=> flag_q[i]);
    end
  end
endmodule

bind pedge_ctrl pedge_ctrl_chk #(.PORT_W(PORT_W), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .irq        (irq),
  .pull_up_en (pull_up_en),
  .pull_dn_en (pull_dn_en),
  .flag_q     (flag_q),
  .ie_q       (ie_q),
  .pol_q      (pol_q),
  .smp_cur    (smp_cur),
  .smp_prev   (smp_prev)
);

// File: tb/tb_pedge_ctrl.sv
`timescale 1ns/1ps
module tb_pedge_ctrl;
  localparam logic [2:0] A_LEVEL = 3'd0, A_PULL = 3'd1, A_POL = 3'd2,
                         A_IRQEN = 3'd3, A_FLAG = 3'd4;
  localparam int K_RDATA = 0, K_UP = 1, K_DN = 2, K_IRQ = 3;

  logic       clk, rst_n, bus_sel, bus_wr, irq;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, pin_in, pull_up_en, pull_dn_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];
  event  chk_ev;

  pedge_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // monitor: pops expected items and compares against live outputs
  initial begin
    forever begin
      @(chk_ev);
      #0.5;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          K_RDATA: act = bus_rdata;
          K_UP:    act = pull_up_en;
          K_DN:    act = pull_dn_en;
          default: act = {7'd0, irq};
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push_exp(int kind, logic [7:0] e, string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #0.2;
    push_exp(K_RDATA, e, tag);
    bus_sel = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #0.5;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic obs(int kind, logic [7:0] e, string tag);
    @(negedge clk);
    push_exp(kind, e, tag);
  endtask

  task automatic set_pin(logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; pin_in = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2 reset state
    rd(A_PULL,  8'h00, "R2 pull reg");
    rd(A_POL,   8'h00, "R2 polarity reg");
    rd(A_IRQEN, 8'h00, "R2 irq enable reg");
    rd(A_FLAG,  8'h00, "R2 flag reg");
    obs(K_UP,  8'h00, "R2 pull_up_en");
    obs(K_DN,  8'h00, "R2 pull_dn_en");
    obs(K_IRQ, 8'h00, "R2 irq");

    // R1 reserved bits; R5 pull direction
    wr(A_PULL, 8'hFF);
    rd(A_PULL, 8'hC3, "R1 pull reserved bits");
    wr(A_POL, 8'h3C);
    rd(A_POL, 8'h00, "R1 polarity reserved bits");
    obs(K_UP, 8'hC3, "R5 pull-up with polarity 0");
    obs(K_DN, 8'h00, "R5 no pull-down with polarity 0");
    wr(A_POL, 8'h41);
    obs(K_UP, 8'h82, "R5 mixed pull-up");
    obs(K_DN, 8'h41, "R5 mixed pull-down");
    wr(A_PULL, 8'h00);
    obs(K_UP, 8'h00, "R5 pull disabled up");
    obs(K_DN, 8'h00, "R5 pull disabled down");
    wr(A_POL, 8'h00);
    rd(3'd7, 8'h00, "R1 unmapped address");

    // R11 level; rising edges with polarity 0 set nothing (R4, R10)
    set_pin(8'hA5);
    rd(A_LEVEL, 8'h81, "R11 level read");
    rd(A_FLAG, 8'h00, "R4 rising ignored at polarity 0");

    // R3 falling edge, latency of three rising edges
    @(negedge clk);
    pin_in = 8'h25;
    repeat (2) @(posedge clk);
    rd(A_FLAG, 8'h00, "R3 flag not yet after two edges");
    rd(A_FLAG, 8'h80, "R3 flag after third edge");

    // R6 irq gating
    obs(K_IRQ, 8'h00, "R6 irq masked");
    wr(A_IRQEN, 8'h80);
    obs(K_IRQ, 8'h01, "R6 irq enabled");
    wr(A_IRQEN, 8'h01);
    obs(K_IRQ, 8'h00, "R6 irq other pin enabled");

    // R7 write-one clear
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, 8'h80, "R7 zero write keeps flag");
    wr(A_FLAG, 8'h80);
    rd(A_FLAG, 8'h00, "R7 one write clears flag");

    // R4 rising polarity
    wr(A_POL, 8'hC3);
    set_pin(8'h24);
    rd(A_FLAG, 8'h00, "R4 falling ignored at polarity 1");
    set_pin(8'h65);
    rd(A_FLAG, 8'h41, "R4 rising edges set flags");
    obs(K_IRQ, 8'h01, "R6 irq from pin 0");
    wr(A_FLAG, 8'hFF);
    rd(A_FLAG, 8'h00, "R7 clear all");
    obs(K_IRQ, 8'h00, "R6 irq drops after clear");

    // R9 polarity change alone
    wr(A_POL, 8'h00);
    repeat (3) @(posedge clk);
    rd(A_FLAG, 8'h00, "R9 polarity to 0 no flag");
    wr(A_POL, 8'hC3);
    repeat (3) @(posedge clk);
    rd(A_FLAG, 8'h00, "R9 polarity to 1 no flag");

    // R10 reserved pins toggling
    set_pin(8'h7D);
    rd(A_FLAG, 8'h00, "R10 reserved edges ignored");
    rd(A_LEVEL, 8'h41, "R11 level hides reserved pins");

    // R8 edge coincides with clear
    set_pin(8'hFD);
    rd(A_FLAG, 8'h80, "R4 pin7 rising flag");
    set_pin(8'h7D);
    rd(A_FLAG, 8'h80, "R4 pin7 falling no change");
    @(negedge clk);
    pin_in = 8'hFD;
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 8'h80;
    @(posedge clk);
    #0.5;
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(A_FLAG, 8'h80, "R8 edge beats clear");
    wr(A_FLAG, 8'h80);
    rd(A_FLAG, 8'h00, "R7 clear without edge");

    wr(A_IRQEN, 8'hFF);
    rd(A_IRQEN, 8'hC3, "R1 irq enable reserved bits");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule